// File: doc/BRIEF.md
# Filtered Message Capture Buffer

This block takes 48-bit messages that arrive from a number of readout channels, each one tagged with the 8-bit number of the channel it came from. A programmable filter looks at that channel number and decides whether the message is kept. The filter holds an 8-bit pattern and an 8-bit per-bit enable. Messages that fail the filter are dropped and leave no trace.

A kept message is written into a 16-bit-wide capture memory. It occupies a slot of four words, and a write pointer gives the slot's base address. The four words go into memory on four consecutive clocks. While they are being written, the message input shows not-ready. The pointer then steps to the next slot. It wraps at the end of the memory, so the oldest entries are overwritten. A host reads the filter and the pointer through a small register port. It reads the capture memory through a separate read port with one cycle of latency.

Top module: `msg_capture_buf`

## Requirements
- R1: In every stored slot, the word whose two low address bits are 00 holds message bits 47:32.
- R2: In every stored slot, the word at low address bits 01 holds message bits 31:16, and the word at low address bits 10 holds message bits 15:0.
- R3: In every stored slot, the word at low address bits 11 holds the channel number zero-extended to 16 bits.
- R4: The write pointer is 14 bits wide and is zero after reset. It is read with `reg_sel`=1 (zero-extended to 16 bits), and a register write with `reg_sel`=1 has no effect on it.
- R5: The write pointer advances by exactly 4 for each stored message. It does not change for a dropped message.
- R6: The filter register is written and read with `reg_sel`=0. Bits 7:0 are the pattern and bits 15:8 are the per-bit enables. A message is stored only when `((chan ^ pattern) & enable) == 0`; any other message is dropped and `msg_ready` stays high.
- R7: The filter resets to 0x0000, and in that state every message is stored.
- R8: The pointer wraps modulo DEPTH words. After DEPTH/4 stored messages it is back at 0, and the next message overwrites slot 0.
- R9: After a message is accepted, `msg_ready` is low for exactly 4 cycles while the four words are written on consecutive clocks. Input offered during those cycles is ignored.
- R10: Host reads of the pointer, the filter and the memory during a write do not alter what is stored. Memory read data appears on the cycle after `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message offered |
| msg_data | input | 48 | Message payload |
| msg_chan | input | 8 | Source channel number |
| msg_ready | output | 1 | High when a message can be accepted |
| reg_sel | input | 1 | 0 selects the filter, 1 selects the write pointer |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value (combinational) |
| mem_rd_en | input | 1 | Memory read strobe |
| mem_rd_addr | input | log2(DEPTH) | Memory word address |
| mem_rd_data | output | 16 | Word read, valid one cycle after the strobe |

## Verification
The bench builds the block with DEPTH=64, which gives 16 slots. With that size, pointer wrap-around and the overwriting of slot 0 happen after only a few messages. The bench sweeps all 256 channel numbers under several filter patterns and enable masks, including all-enabled, none-enabled and sparse masks. It computes the keep/drop decision and the expected pointer arithmetically. Directed cases cover input offered while not ready and host reads issued during a write.

// File: rtl/msg_capture_pkg.sv
package msg_capture_pkg;
    localparam int MSG_W  = 48;
    localparam int CH_W   = 8;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 14;

    typedef struct packed {
        logic              busy;
        logic [1:0]        idx;
        logic [MSG_W-1:0]  msg;
        logic [CH_W-1:0]   chan;
        logic [PTR_W-1:0]  ptr;
        logic [WORD_W-1:0] filt;
    } cap_state_t;

    // Word placed at slot offset idx
    function automatic logic [WORD_W-1:0] slot_word(
        input logic [1:0] idx, input logic [MSG_W-1:0] msg, input logic [CH_W-1:0] chan);
        case (idx)
            2'd0:    slot_word = msg[47:32];
            2'd1:    slot_word = msg[31:16];
            2'd2:    slot_word = msg[15:0];
            default: slot_word = WORD_W'(chan);
        endcase
    endfunction
endpackage

// File: rtl/chan_filter.sv
module chan_filter #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] chan,
    input  logic [CH_W-1:0] pattern,
    input  logic [CH_W-1:0] enable,
    output logic            keep
);
    logic [CH_W-1:0] miss;

    for (genvar b = 0; b < CH_W; b++) begin : g_bit
        assign miss[b] = enable[b] & (chan[b] ^ pattern[b]);
    end

    assign keep = ~|miss;
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int DEPTH = 4096,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import msg_capture_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [MSG_W-1:0]  msg_data,
    input  logic [CH_W-1:0]   msg_chan,
    input  logic              keep,
    input  logic              filt_we,
    input  logic [WORD_W-1:0] filt_wdata,
    output logic              msg_ready,
    output logic [WORD_W-1:0] filt,
    output logic [PTR_W-1:0]  ptr,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W-1:0] wdata
);
    localparam logic [PTR_W-1:0] PTR_MASK = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] SLOT     = PTR_W'(4);

    cap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (filt_we) s_d.filt = filt_wdata;
        if (s_q.busy) begin
            s_d.idx = s_q.idx + 2'd1;
            if (s_q.idx == 2'd3) begin
                s_d.busy = 1'b0;
                s_d.ptr  = (s_q.ptr + SLOT) & PTR_MASK;
            end
        end else if (msg_valid && keep) begin
            s_d.busy = 1'b1;
            s_d.idx  = 2'd0;
            s_d.msg  = msg_data;
            s_d.chan = msg_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign msg_ready = ~s_q.busy;
    assign filt      = s_q.filt;
    assign ptr       = s_q.ptr;
    assign we        = s_q.busy;
    assign waddr     = {s_q.ptr[AW-1:2], s_q.idx};
    assign wdata     = slot_word(s_q.idx, s_q.msg, s_q.chan);
endmodule

// File: rtl/msg_capture_buf.sv
module msg_capture_buf
    import msg_capture_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     msg_valid,
    input  logic [47:0]              msg_data,
    input  logic [7:0]               msg_chan,
    output logic                     msg_ready,
    input  logic                     reg_sel,
    input  logic                     reg_wr,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              reg_rdata,
    input  logic                     mem_rd_en,
    input  logic [$clog2(DEPTH)-1:0] mem_rd_addr,
    output logic [15:0]              mem_rd_data
);
    localparam int AW = $clog2(DEPTH);

    logic              flt_pass;
    logic [WORD_W-1:0] filt;
    logic [PTR_W-1:0]  wr_ptr;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [WORD_W-1:0] ram_wdata;

    chan_filter #(.CH_W(CH_W)) u_filter (
        .chan    (msg_chan),
        .pattern (filt[CH_W-1:0]),
        .enable  (filt[2*CH_W-1:CH_W]),
        .keep    (flt_pass)
    );

    cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_data   (msg_data),
        .msg_chan   (msg_chan),
        .keep       (flt_pass),
        .filt_we    (reg_wr & ~reg_sel),
        .filt_wdata (reg_wdata),
        .msg_ready  (msg_ready),
        .filt       (filt),
        .ptr        (wr_ptr),
        .we         (ram_we),
        .waddr      (ram_waddr),
        .wdata      (ram_wdata)
    );

    cap_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (mem_rd_en),
        .raddr (mem_rd_addr),
        .rdata (mem_rd_data)
    );

    assign reg_rdata = reg_sel ? WORD_W'(wr_ptr) : filt;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int DEPTH = 4096,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          msg_valid,
    input logic          msg_ready,
    input logic          pass,
    input logic          we,
    input logic [AW-1:0] waddr,
    input logic [13:0]   ptr
);
    localparam logic [13:0] MASK = 14'(DEPTH - 1);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> (ptr == (($past(ptr) + 14'd4) & MASK))); // R5

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr[1:0] == 2'b00) && ((ptr & ~MASK) == 14'd0)); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && pass) |=> !msg_ready); // R9

    AST_DROP_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !pass) |=> msg_ready); // R6

    AST_WORDS_CONSECUTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr[1:0] != 2'b11) |=> (we && waddr == $past(waddr) + AW'(1))); // R9

    AST_NO_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> !we); // R9
endmodule

bind msg_capture_buf cap_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .pass      (flt_pass),
    .we        (ram_we),
    .waddr     (ram_waddr),
    .ptr       (wr_ptr)
);

// File: tb/tb_msg_capture_buf.sv
module tb_msg_capture_buf;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          msg_valid = 0;
    logic [47:0]   msg_data = '0;
    logic [7:0]    msg_chan = '0;
    logic          msg_ready;
    logic          reg_sel = 0;
    logic          reg_wr = 0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          mem_rd_en = 0;
    logic [AW-1:0] mem_rd_addr = '0;
    logic [15:0]   mem_rd_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    int  exp_ptr = 0;

    always #10 clk = ~clk;

    msg_capture_buf #(.DEPTH(DEPTH)) dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input int k, input logic [7:0] ch);
        return {8'hC3, ch, 16'(k * 3 + 1), ~16'(k)};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        exp_ptr = 0;
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] v);
        @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic rd_mem(input int a, output logic [15:0] v);
        @(negedge clk); mem_rd_en = 1; mem_rd_addr = AW'(a);
        @(negedge clk); mem_rd_en = 0; v = mem_rd_data;
    endtask

    // Offers one message; returns ready just after the accept edge and the low-cycle count
    task automatic send(input logic [47:0] d, input logic [7:0] ch, output logic rdy1, output int lows);
        @(negedge clk); msg_valid = 1; msg_data = d; msg_chan = ch;
        @(negedge clk); msg_valid = 0;
        rdy1 = msg_ready;
        lows = 0;
        while (!msg_ready && lows < 20) begin lows++; @(negedge clk); end
    endtask

    task automatic check_slot(input string tag, input int base, input logic [47:0] d, input logic [7:0] ch);
        logic [15:0] v;
        rd_mem(base + 0, v); check({"R1 ", tag}, v, d[47:32]);
        rd_mem(base + 1, v); check({"R2 ", tag}, v, d[31:16]);
        rd_mem(base + 2, v); check({"R2 ", tag}, v, d[15:0]);
        rd_mem(base + 3, v); check({"R3 ", tag}, v, {8'h00, ch});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic        r;
        int          lows;
        logic [15:0] filters [5] = '{16'h0000, 16'hFF5A, 16'h0F03, 16'h8000, 16'h3C24};
        int          k = 0;

        do_reset();
        // R4: reset state and read-only pointer
        rd_reg(1, v); check("R4 ptr after reset", v, 16'h0000);
        rd_reg(0, v); check("R7 filter reset", v, 16'h0000);
        check("R9 ready after reset", msg_ready, 1'b1);
        wr_reg(1, 16'h0024);
        rd_reg(1, v); check("R4 ptr write ignored", v, 16'h0000);

        // R7: default filter stores and places words
        send(mk(1, 8'hA7), 8'hA7, r, lows);
        check("R7 default stores", r, 1'b0);
        check("R9 four busy cycles", lows, 4);
        exp_ptr = (exp_ptr + 4) % DEPTH;
        rd_reg(1, v); check("R5 ptr step", v, 16'(exp_ptr));
        check_slot("first slot", 0, mk(1, 8'hA7), 8'hA7);

        // R6/R5/R9: filter sweep over all channel numbers
        foreach (filters[f]) begin
            logic [7:0] pat, en;
            pat = filters[f][7:0]; en = filters[f][15:8];
            wr_reg(0, filters[f]);
            rd_reg(0, v); check("R6 filter readback", v, filters[f]);
            for (int ch = 0; ch < 256; ch++) begin
                logic keep;
                int   slot;
                keep = (((8'(ch) ^ pat) & en) == 8'h00);
                slot = exp_ptr;
                k++;
                send(mk(k, 8'(ch)), 8'(ch), r, lows);
                check("R6 keep decision", r, !keep);
                if (keep) begin
                    check("R9 busy length", lows, 4);
                    exp_ptr = (exp_ptr + 4) % DEPTH;
                end
                rd_reg(1, v); check("R5 ptr tracks stores", v, 16'(exp_ptr));
                if (keep && (ch % 37 == 0)) check_slot("sweep slot", slot, mk(k, 8'(ch)), 8'(ch));
            end
        end
        wr_reg(0, 16'h0000);

        // R8: wrap and overwrite of slot 0
        do_reset();
        for (int i = 0; i < DEPTH / 4; i++) send(mk(500 + i, 8'(i)), 8'(i), r, lows);
        rd_reg(1, v); check("R8 ptr wraps to 0", v, 16'h0000);
        check_slot("before overwrite", DEPTH - 4, mk(500 + DEPTH / 4 - 1, 8'(DEPTH / 4 - 1)), 8'(DEPTH / 4 - 1));
        send(mk(900, 8'h5E), 8'h5E, r, lows);
        check_slot("R8 overwrite", 0, mk(900, 8'h5E), 8'h5E);
        rd_reg(1, v); check("R8 ptr after overwrite", v, 16'h0004);

        // R9: input offered while busy is ignored
        @(negedge clk); msg_valid = 1; msg_data = mk(901, 8'h11); msg_chan = 8'h11;
        @(negedge clk); check("R9 not ready", msg_ready, 1'b0);
        msg_data = mk(902, 8'h22); msg_chan = 8'h22;
        @(negedge clk); @(negedge clk); msg_valid = 0;
        while (!msg_ready) @(negedge clk);
        rd_reg(1, v); check("R9 busy input ignored", v, 16'h0008);
        check_slot("R9 first kept", 4, mk(901, 8'h11), 8'h11);

        // R10: host reads during a write
        @(negedge clk); msg_valid = 1; msg_data = mk(903, 8'h33); msg_chan = 8'h33;
        @(negedge clk); msg_valid = 0;
        rd_reg(1, v); check("R10 ptr during write", v, 16'h0008);
        rd_reg(0, v); check("R10 filter during write", v, 16'h0000);
        mem_rd_en = 1; mem_rd_addr = AW'(4);
        @(negedge clk); mem_rd_en = 0;
        check("R10 read latency one cycle", mem_rd_data, mk(901, 8'h11)[47:32]);
        mem_rd_en = 1; mem_rd_addr = AW'(7);
        @(negedge clk); mem_rd_en = 0;
        check("R10 read during write", mem_rd_data, 16'h0011);
        while (!msg_ready) @(negedge clk);
        check_slot("R10 slot intact", 8, mk(903, 8'h33), 8'h33);
        rd_reg(1, v); check("R10 ptr after write", v, 16'h000C);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule